// File: doc/BRIEF.md
# Dual-Width Stack Push/Pop Unit

This block carries out stack pushes, pops and a push-all of the eight general registers for a segmented core. Stack addresses are formed from a stack-segment base plus the stack pointer. The pointer is either 16 or 32 bits wide, and the selected pointer mode is independent of the operand size of 2 or 4 bytes. The block reads registers and writes the stack pointer through register-file ports. It reaches memory through a single request/response port, and that port reports completion or a fault for each request.

A command is accepted in `ST_IDLE`. A single push or pop moves `ST_IDLE -> ST_ACC_REQ -> ST_ACC_WAIT -> ST_IDLE`. A push-all moves `ST_IDLE -> ST_PROBE_REQ -> ST_PROBE_WAIT` and first asks memory whether the whole target region is writable. After a clean probe it loops `ST_ACC_REQ -> ST_ACC_WAIT` eight times and then returns to `ST_IDLE`. A faulting response in either wait state leads straight back to `ST_IDLE` with a fault pulse. A request is held in a `*_REQ` state until memory takes it. The stack pointer is written only in the cycle after a successful response.

Top module: `stack_unit`

## Requirements
- R1: The linear address is `ss_base + p` in 32-bit pointer mode, with no wrap of `p`. In 16-bit pointer mode it is `ss_base + (p mod 65536)`. Here `p` is the post-decrement pointer for a push and the current pointer for a pop.
- R2: A push (`cmd_op` = 2'b00) issues one write of `cmd_data` at the pointer minus the operand size. `mem_size` is 4 when `cmd_wide` is 1 and 2 otherwise, and `mem_wdata` is zero above the operand bytes.
- R3: The stack pointer register (index 4 on `rf_waddr`) is written only in the cycle right after a non-faulting response. The written value is the pointer moved by the operand size.
- R4: A pop (`cmd_op` = 2'b01) reads at the current pointer and then raises the pointer by 2 or 4. `pop_data` holds the low operand bytes of `mem_rdata`, zero-extended.
- R5: In 16-bit pointer mode, bits 31:16 of the pointer are kept and bits 15:0 wrap modulo 65536. This holds for 4-byte operands too.
- R6: A push-all (`cmd_op[1]` = 1) first sends one probe (`mem_probe` = 1, `mem_we` = 0) covering 16 or 32 bytes below the pointer. If the probe faults, no write follows and no register changes.
- R7: A push-all writes registers 0, 1, 2, 3, then the pointer value captured at command acceptance, then 5, 6, 7, at falling addresses. The pointer is committed after each write.
- R8: A faulting response to a push or pop gives a one-cycle `fault` pulse with no register write, and the block returns to idle.
- R9: Only one memory request is outstanding at a time, and a request keeps its fields stable until `mem_req_ready`. `cmd_ready` is high only when the block is idle with no pointer write pending.
- R10: A command that completes without a fault gives a one-cycle `done` pulse. `done` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 00 push, 01 pop, 1x push-all |
| cmd_wide | input | 1 | Operand size: 1 = 4 bytes, 0 = 2 bytes |
| cmd_data | input | 32 | Value to push |
| sp32_mode | input | 1 | 1 = 32-bit pointer, 0 = 16-bit pointer |
| ss_base | input | 32 | Stack segment base |
| rf_raddr | output | 3 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data |
| rf_we | output | 1 | Stack pointer write strobe |
| rf_waddr | output | 3 | Register index written (pointer) |
| rf_wdata | output | 32 | New pointer value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes request |
| mem_we | output | 1 | Request is a write |
| mem_probe | output | 1 | Request is a writability probe only |
| mem_size | output | 6 | Bytes covered by the request |
| mem_addr | output | 32 | Linear address, little-endian access |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_fault | input | 1 | Response reports a fault |
| mem_rdata | input | 32 | Read data |
| pop_data | output | 32 | Last popped value |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Fault pulse |

## Verification
A response arriving in `ST_ACC_WAIT` does two jobs in one cycle: it decides between commit and fault, and within a push-all it also advances to the next register while the pointer write to the file is still in flight. This case is provoked by push-alls under a stalling memory, where the fifth slot must carry the pointer captured at acceptance rather than the moved pointer being written that same cycle. The bench's behavioural model predicts every request and the final register file. Separately, a probe fault is injected, and single pushes and pops are made to fault, to show that no pointer write accompanies a fault.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE_REQ,
        ST_PROBE_WAIT,
        ST_ACC_REQ,
        ST_ACC_WAIT
    } stk_state_e;

    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_ALL  = 2'b10
    } stk_op_e;

endpackage

// File: rtl/stk_ptr_calc.sv
module stk_ptr_calc #(
    parameter int W = 32
) (
    input  logic         mode32,
    input  logic         move_down,
    input  logic [W-1:0] sp,
    input  logic [W-1:0] step,
    input  logic [W-1:0] base,
    output logic [W-1:0] new_sp,
    output logic [W-1:0] lin_addr
);
    localparam int HALF = W / 2;

    logic [W-1:0] moved;
    logic [W-1:0] eff;

    always_comb begin
        moved  = move_down ? (sp - step) : (sp + step);
        new_sp = mode32 ? moved : {sp[W-1:HALF], moved[HALF-1:0]};
        eff    = move_down ? new_sp : sp;
        lin_addr = base + (mode32 ? eff : {{HALF{1'b0}}, eff[HALF-1:0]});
    end
endmodule

// File: rtl/stk_wdata_sel.sv
module stk_wdata_sel #(
    parameter int W      = 32,
    parameter int NREG   = 8,
    parameter int SP_IDX = 4
) (
    input  logic                    all_mode,
    input  logic [$clog2(NREG)-1:0] idx,
    input  logic                    wide,
    input  logic [W-1:0]            cmd_val,
    input  logic [W-1:0]            reg_val,
    input  logic [W-1:0]            sp_snap,
    output logic [W-1:0]            wdata
);
    localparam int IW   = $clog2(NREG);
    localparam int HALF = W / 2;

    logic [W-1:0] raw;

    always_comb begin
        if (!all_mode)
            raw = cmd_val;
        else if (idx == IW'(SP_IDX))
            raw = sp_snap;
        else
            raw = reg_val;
        wdata = wide ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
    end
endmodule

// File: rtl/stack_unit.sv
module stack_unit #(
    parameter int W      = 32,
    parameter int NREG   = 8,
    parameter int SP_IDX = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmd_valid,
    output logic                            cmd_ready,
    input  logic [1:0]                      cmd_op,
    input  logic                            cmd_wide,
    input  logic [W-1:0]                    cmd_data,
    input  logic                            sp32_mode,
    input  logic [W-1:0]                    ss_base,
    output logic [$clog2(NREG)-1:0]         rf_raddr,
    input  logic [W-1:0]                    rf_rdata,
    output logic                            rf_we,
    output logic [$clog2(NREG)-1:0]         rf_waddr,
    output logic [W-1:0]                    rf_wdata,
    output logic                            mem_req_valid,
    input  logic                            mem_req_ready,
    output logic                            mem_we,
    output logic                            mem_probe,
    output logic [$clog2(NREG*W/8+1)-1:0]   mem_size,
    output logic [W-1:0]                    mem_addr,
    output logic [W-1:0]                    mem_wdata,
    input  logic                            mem_rsp_valid,
    input  logic                            mem_rsp_fault,
    input  logic [W-1:0]                    mem_rdata,
    output logic [W-1:0]                    pop_data,
    output logic                            done,
    output logic                            fault
);
    import stk_pkg::*;

    localparam int IW   = $clog2(NREG);
    localparam int HALF = W / 2;
    localparam int NB   = W / 8;
    localparam int SZW  = $clog2(NREG * NB + 1);
    localparam logic [W-1:0] STEP_WIDE   = W'(NB);
    localparam logic [W-1:0] STEP_NARROW = W'(NB / 2);
    localparam logic [W-1:0] AREA_WIDE   = W'(NREG * NB);
    localparam logic [W-1:0] AREA_NARROW = W'(NREG * NB / 2);

    stk_state_e state, state_nx;
    stk_op_e    op_q;
    logic           wide_q;
    logic           mode_q;
    logic [W-1:0]   data_q;
    logic [W-1:0]   sp_q;
    logic [W-1:0]   sp_snap_q;
    logic [IW-1:0]  idx_q;

    logic           accept;
    logic           in_probe;
    logic           last_slot;
    logic [W-1:0]   step_bytes;
    logic [W-1:0]   calc_sp;
    logic [W-1:0]   calc_addr;
    logic [W-1:0]   push_val;

    assign accept    = cmd_valid && cmd_ready;
    assign in_probe  = (state == ST_PROBE_REQ) || (state == ST_PROBE_WAIT);
    assign last_slot = (op_q != OP_ALL) || (idx_q == IW'(NREG - 1));

    always_comb begin
        if (in_probe)
            step_bytes = wide_q ? AREA_WIDE : AREA_NARROW;
        else
            step_bytes = wide_q ? STEP_WIDE : STEP_NARROW;
    end

    stk_ptr_calc #(.W(W)) u_ptr (
        .mode32   (mode_q),
        .move_down(op_q != OP_POP),
        .sp       (sp_q),
        .step     (step_bytes),
        .base     (ss_base),
        .new_sp   (calc_sp),
        .lin_addr (calc_addr)
    );

    stk_wdata_sel #(.W(W), .NREG(NREG), .SP_IDX(SP_IDX)) u_wsel (
        .all_mode(op_q == OP_ALL),
        .idx     (idx_q),
        .wide    (wide_q),
        .cmd_val (data_q),
        .reg_val (rf_rdata),
        .sp_snap (sp_snap_q),
        .wdata   (push_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:
                if (accept)
                    state_nx = cmd_op[1] ? ST_PROBE_REQ : ST_ACC_REQ;
            ST_PROBE_REQ:
                if (mem_req_ready) state_nx = ST_PROBE_WAIT;
            ST_PROBE_WAIT:
                if (mem_rsp_valid)
                    state_nx = mem_rsp_fault ? ST_IDLE : ST_ACC_REQ;
            ST_ACC_REQ:
                if (mem_req_ready) state_nx = ST_ACC_WAIT;
            ST_ACC_WAIT:
                if (mem_rsp_valid)
                    state_nx = (mem_rsp_fault || last_slot) ? ST_IDLE : ST_ACC_REQ;
            default:
                state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        cmd_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_probe     = 1'b0;
        mem_we        = 1'b0;
        mem_wdata     = '0;
        rf_raddr      = idx_q;
        unique case (state)
            ST_IDLE: begin
                cmd_ready = !rf_we;
                rf_raddr  = IW'(SP_IDX);
            end
            ST_PROBE_REQ: begin
                mem_req_valid = 1'b1;
                mem_probe     = 1'b1;
            end
            ST_ACC_REQ: begin
                mem_req_valid = 1'b1;
                mem_we        = (op_q != OP_POP);
                mem_wdata     = (op_q != OP_POP) ? push_val : '0;
            end
            default: ;
        endcase
        mem_addr = calc_addr;
        mem_size = step_bytes[SZW-1:0];
        rf_waddr = IW'(SP_IDX);
    end

    // command capture, commit and result pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_PUSH;
            wide_q    <= 1'b0;
            mode_q    <= 1'b0;
            data_q    <= '0;
            sp_q      <= '0;
            sp_snap_q <= '0;
            idx_q     <= '0;
            rf_we     <= 1'b0;
            rf_wdata  <= '0;
            pop_data  <= '0;
            done      <= 1'b0;
            fault     <= 1'b0;
        end else begin
            rf_we <= 1'b0;
            done  <= 1'b0;
            fault <= 1'b0;
            if (state == ST_IDLE && accept) begin
                op_q      <= cmd_op[1] ? OP_ALL : (cmd_op[0] ? OP_POP : OP_PUSH);
                wide_q    <= cmd_wide;
                mode_q    <= sp32_mode;
                data_q    <= cmd_data;
                sp_q      <= rf_rdata;
                sp_snap_q <= rf_rdata;
                idx_q     <= '0;
            end
            if (state == ST_PROBE_WAIT && mem_rsp_valid && mem_rsp_fault)
                fault <= 1'b1;
            if (state == ST_ACC_WAIT && mem_rsp_valid) begin
                if (mem_rsp_fault) begin
                    fault <= 1'b1;
                end else begin
                    rf_we    <= 1'b1;
                    rf_wdata <= calc_sp;
                    sp_q     <= calc_sp;
                    if (op_q == OP_POP)
                        pop_data <= wide_q ? mem_rdata
                                           : {{HALF{1'b0}}, mem_rdata[HALF-1:0]};
                    if (last_slot)
                        done <= 1'b1;
                    else
                        idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // R3
    rf_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(mem_rsp_valid && !mem_rsp_fault));

    // R8
    fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(mem_rsp_valid && mem_rsp_fault));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault}));

    // R9
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_req_valid);
endmodule

// File: tb/stack_unit_test.sv
module stack_unit_test;

    typedef struct {
        bit        we;
        bit        probe;
        bit [31:0] addr;
        int        size;
        bit [31:0] data;
    } req_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 0;
    logic        cmd_wide = 0;
    logic [31:0] cmd_data = 0;
    logic        sp32_mode = 0;
    logic [31:0] ss_base = 32'h0001_0000;
    logic [2:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        rf_we;
    logic [2:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1;
    logic        mem_we;
    logic        mem_probe;
    logic [5:0]  mem_size;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rsp_valid = 0;
    logic        mem_rsp_fault = 0;
    logic [31:0] mem_rdata = 0;
    logic [31:0] pop_data;
    logic        done;
    logic        fault;

    always #10 clk = ~clk;

    stack_unit uut (.*);

    logic [31:0] rf_arr [0:7];
    assign rf_rdata = rf_arr[rf_raddr];
    always @(posedge clk) if (rf_we) rf_arr[rf_waddr] <= rf_wdata;

    bit [7:0]  mem [int unsigned];
    bit [31:0] mregs [0:7];
    req_t      exp_q [$];
    int        checks = 0;
    int        fails = 0;
    int        cyc = 0;
    bit        stall_en = 0;
    bit        finished = 0;
    longint    flt_lo = 1;
    longint    flt_hi = 0;
    bit        pend = 0;
    bit        pend_fault = 0;
    bit [31:0] pend_data = 0;
    bit        seen_done = 0;
    bit        seen_fault = 0;
    bit        hold_chk = 0;
    bit [31:0] hold_addr = 0;

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] mv(bit [31:0] sp, int delta, bit m32);
        bit [15:0] lo;
        lo = 16'(sp[15:0] + delta);
        return m32 ? 32'(sp + delta) : {sp[31:16], lo};
    endfunction

    function automatic bit [31:0] lin(bit [31:0] p, bit m32);
        return ss_base + (m32 ? p : {16'h0, p[15:0]});
    endfunction

    function automatic bit hits(bit [31:0] a, int n);
        return (longint'(a) <= flt_hi) && (longint'(a) + n - 1 >= flt_lo);
    endfunction

    function automatic bit [31:0] rd(bit [31:0] a, int n);
        bit [31:0] v = 0;
        for (int i = 0; i < n; i++)
            if (mem.exists(a + i)) v[8*i +: 8] = mem[a + i];
        return v;
    endfunction

    task automatic step();
        bit rsp_ok;
        bit rsp_bad;
        @(negedge clk);
        cyc++;
        rsp_ok  = mem_rsp_valid && !mem_rsp_fault;
        rsp_bad = mem_rsp_valid && mem_rsp_fault;
        // R3: a pointer write only follows a good response
        if (rf_we) check(rsp_ok, "R3 commit after good response", rf_we, rsp_ok);
        // R10 / R8
        if (done) begin seen_done = 1; check(rsp_ok && !fault, "R10 done pulse", fault, 0); end
        if (fault) begin seen_fault = 1; check(rsp_bad, "R8 fault follows fault response", rsp_bad, 1); end
        // R9: held request
        if (hold_chk) begin
            check(mem_req_valid && mem_addr == hold_addr, "R9 request held", mem_addr, hold_addr);
            hold_chk = 0;
        end
        mem_rsp_valid = 0;
        mem_rsp_fault = 0;
        if (pend) begin
            mem_rsp_valid = 1;
            mem_rsp_fault = pend_fault;
            mem_rdata     = pend_data;
            pend = 0;
        end
        mem_req_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
        if (mem_req_valid && !mem_req_ready) begin
            hold_chk = 1;
            hold_addr = mem_addr;
        end
        if (mem_req_valid && mem_req_ready) begin
            int n;
            n = int'(mem_size);
            if (exp_q.size() == 0) begin
                check(0, "R9 unexpected request", mem_addr, 0);
            end else begin
                req_t e;
                e = exp_q.pop_front();
                check(mem_we == e.we && mem_probe == e.probe, "R6 request kind",
                      {mem_we, mem_probe}, {e.we, e.probe});
                check(mem_addr == e.addr, "R1 address", mem_addr, e.addr);
                check(n == e.size, "R2 size", n, e.size);
                if (e.we) check(mem_wdata == e.data, "R7 write data", mem_wdata, e.data);
            end
            pend = 1;
            pend_fault = hits(mem_addr, n);
            pend_data = 0;
            if (!mem_probe && !pend_fault) begin
                if (mem_we)
                    for (int i = 0; i < n; i++) mem[mem_addr + i] = mem_wdata[8*i +: 8];
                else begin
                    pend_data = rd(mem_addr, n);
                    if (n == 2) pend_data[31:16] = 16'hA5A5;
                end
            end
        end
    endtask

    // op: 0 push, 1 pop, 2 push-all
    task automatic run_cmd(int op, bit wide, bit [31:0] data, bit m32, string req);
        bit        exp_ok = 1;
        bit [31:0] exp_pop = 0;
        int        n;
        bit [31:0] sp, sp0, a, v;
        n = wide ? 4 : 2;
        sp = mregs[4];
        exp_q.delete();
        if (op == 0) begin
            sp = mv(sp, -n, m32); a = lin(sp, m32);
            v = wide ? data : {16'h0, data[15:0]};
            exp_q.push_back('{1, 0, a, n, v});
            if (hits(a, n)) exp_ok = 0; else mregs[4] = sp;
        end else if (op == 1) begin
            a = lin(sp, m32);
            exp_q.push_back('{0, 0, a, n, 0});
            if (hits(a, n)) exp_ok = 0;
            else begin exp_pop = rd(a, n); mregs[4] = mv(sp, n, m32); end
        end else begin
            sp0 = sp;
            a = lin(mv(sp, -8 * n, m32), m32);
            exp_q.push_back('{0, 1, a, 8 * n, 0});
            if (hits(a, 8 * n)) exp_ok = 0;
            else
                for (int i = 0; i < 8; i++) begin
                    v = (i == 4) ? sp0 : mregs[i];
                    if (!wide) v[31:16] = 0;
                    sp = mv(sp, -n, m32); a = lin(sp, m32);
                    exp_q.push_back('{1, 0, a, n, v});
                    mregs[4] = sp;
                end
        end
        seen_done = 0; seen_fault = 0;
        sp32_mode = m32; cmd_wide = wide; cmd_data = data;
        cmd_op = (op == 2) ? 2'b10 : 2'(op);
        cmd_valid = 1;
        for (int t = 0; t < 50 && !cmd_ready; t++) step();
        step();
        cmd_valid = 0;
        for (int t = 0; t < 300 && !seen_done && !seen_fault; t++) step();
        step();
        check(seen_done == exp_ok && seen_fault == !exp_ok, {req, " outcome"},
              {seen_done, seen_fault}, {exp_ok, !exp_ok});
        check(exp_q.size() == 0, {req, " all requests issued"}, exp_q.size(), 0);
        if (op == 1 && exp_ok) check(pop_data == exp_pop, {req, " R4 pop data"}, pop_data, exp_pop);
        for (int i = 0; i < 8; i++)
            check(rf_arr[i] == mregs[i], {req, " register file"}, rf_arr[i], mregs[i]);
        check(cmd_ready == 1, {req, " R9 idle again"}, cmd_ready, 1);
    endtask

    task automatic set_sp(bit [31:0] v);
        rf_arr[4] = v;
        mregs[4] = v;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            rf_arr[i] = 32'h1000_0101 * (i + 1) ^ 32'h00C0_FFEE;
            mregs[i] = rf_arr[i];
        end
        repeat (3) @(negedge clk);
        // reset state
        check(cmd_ready == 1 && mem_req_valid == 0, "R9 reset idle", {cmd_ready, mem_req_valid}, 2'b10);
        check(done == 0 && fault == 0 && rf_we == 0, "R10 reset pulses low", {done, fault, rf_we}, 0);
        rst_n = 1;
        step();

        // R2 R1 R5: 16-bit pointer, 2-byte push
        set_sp(32'h1234_0100);
        run_cmd(0, 0, 32'hDEAD_BEEF, 0, "R2 push16 narrow");
        // R4: pop it back
        run_cmd(1, 0, 0, 0, "R4 pop16 narrow");
        // R5: 4-byte push wraps below zero in 16-bit mode
        set_sp(32'hABCD_0002);
        run_cmd(0, 1, 32'h0BAD_F00D, 0, "R5 push wide wrap");
        run_cmd(1, 1, 0, 0, "R5 pop wide wrap");
        // R1: 32-bit pointer crosses 64 KiB with no wrap
        set_sp(32'h0001_0002);
        run_cmd(0, 1, 32'h1357_9BDF, 1, "R1 push32 no wrap");
        run_cmd(0, 0, 32'hFFFF_4242, 1, "R2 push32 narrow operand");
        run_cmd(1, 0, 0, 1, "R4 pop32 narrow");
        run_cmd(1, 1, 0, 1, "R4 pop32 wide");
        // R7: push-all with a stalling memory
        stall_en = 1;
        set_sp(32'h5555_0010);
        run_cmd(2, 0, 0, 0, "R7 push-all narrow wrap");
        set_sp(32'h0002_0040);
        run_cmd(2, 1, 0, 1, "R7 push-all wide");
        run_cmd(1, 1, 0, 1, "R7 pop back last register");
        stall_en = 0;
        // R6: probe fault leaves everything untouched
        set_sp(32'h0000_0800);
        flt_lo = 32'h0001_07F0; flt_hi = 32'h0001_07F0;
        run_cmd(2, 1, 0, 0, "R6 push-all probe fault");
        check(!mem.exists(32'h0001_07FC), "R6 no write after probe fault", 0, 0);
        // R8: single push and pop fault
        flt_lo = 32'h0001_07FE; flt_hi = 32'h0001_0801;
        run_cmd(0, 0, 32'h7777, 0, "R8 push fault");
        run_cmd(1, 1, 0, 0, "R8 pop fault");
        flt_lo = 1; flt_hi = 0;
        run_cmd(1, 0, 0, 0, "R4 pop after faults");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule